// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a single activity line toggled by a processor and signals a stall when the line stops moving. A free-running counter advances once per clock. Any change of level on the activity line clears it, whether the line rises or falls. If the counter reaches a timeout set in clock cycles, the active-low watchdog output drops. The output can feed a non-maskable interrupt or a manual reset input. The timeout is a parameter. A roughly 1.6 s supervision window becomes a cycle count at the chosen clock rate.

The activity line is asynchronous. It passes through a flop synchronizer, and the edge detector compares each synchronized sample with the one before it. The active-low system reset clears the counter and keeps it cleared, so the supervision window opens only once reset is released. A supply-low flag pulls the output low at any time, whatever the timer holds. An enable input stands in for leaving the activity line unconnected. With enable low, the output follows only the supply-low flag and works as a low-line indicator. The counter stops at the timeout value and never wraps, so a stall stays reported until the line toggles again or reset arrives.

Top module: `stall_watchdog`

## Requirements
- R1: With `wd_en` high, `rst_n` high and no level change on `wdi`, `wdo_n` is still high after TIMEOUT_CYCLES-1 rising clock edges counted from the counter's last clear. It is low after TIMEOUT_CYCLES such edges. After reset release the count starts at the first edge that samples `rst_n` high.
- R2: A rising change and a falling change on `wdi` both clear the timer. A change applied between two edges clears the counter on the third rising edge after it: two for the synchronizer and one for the counter register.
- R3: While `rst_n` is low, the counter stays cleared and `wdo_n` stays high for any reset length (when `supply_low` is low). The timeout is measured from the release.
- R4: `supply_low` high drives `wdo_n` low with no clock delay. This holds in every timer state, during reset and while disabled. When the flag drops, the output returns to the level the timer state gives.
- R5: With `wd_en` low, the counter is held cleared and `wdo_n` equals the inverse of `supply_low` for any length of time. After `wd_en` returns high, a full TIMEOUT_CYCLES window is counted from the first edge that samples it high.
- R6: Once low through a timeout, `wdo_n` stays low until a `wdi` change clears the timer, when it goes high on the third edge after the change, or until `rst_n` goes low, when it goes high on the next edge.
- R7: The counter saturates at TIMEOUT_CYCLES. `wdo_n` stays low for any stall length and never returns high on its own.
- R8: When a `wdi` change clears the counter on the same edge on which the count would reach TIMEOUT_CYCLES, the clear wins and `wdo_n` shows no low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous system reset; clears and holds the timer |
| wd_en | input | 1 | Watchdog enable; low models an unconnected activity line |
| wdi | input | 1 | Asynchronous processor activity line |
| supply_low | input | 1 | Undervoltage flag; forces the output low |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
Two functions can meet in one cycle: the clear caused by an activity edge and the counter arriving at the timeout. The bench lets the counter run from a known clear and then toggles the activity line at the exact negative edge from which the three-edge clear latency lands on the edge where the count would reach the limit. It expects the output to stay high on every sample around that edge. A one-cycle low pulse, which a design that lets expiry beat the clear would produce, is reported as a failure. Supply-low forcing is also overlapped with counting, reset and disable, so that the output can be judged apart from the timer state.

// File: rtl/sw_pkg.sv
package sw_pkg;

  // Saturating increment: the value stays at lim once reached.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    if (v >= lim) return lim;
    return v + 32'd1;
  endfunction

  // The timer is expired when it sits at the limit.
  function automatic logic at_limit(input logic [31:0] v, input logic [31:0] lim);
    return (v == lim);
  endfunction

  // Active-low output level from the three contributing conditions.
  function automatic logic out_level(input logic low_supply, input logic enabled,
                                     input logic expired);
    return !(low_supply || (enabled && expired));
  endfunction

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain_q[i] <= din;
      end else begin : g_next
        always_ff @(posedge clk) chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sw_edge_det.sv
module sw_edge_det (
  input  logic clk,
  input  logic level,
  output logic toggled
);
  logic prev_q;

  always_ff @(posedge clk) prev_q <= level;

  assign toggled = (level != prev_q);
endmodule

// File: rtl/sw_timer.sv
module sw_timer #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic          expired
);
  localparam logic [31:0] LIM32 = 32'(LIMIT);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_inc;

  assign count_inc = CW'(sw_pkg::sat_inc(32'(count_q), LIM32));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || clear) count_q <= '0;
    else                            count_q <= count_inc;
  end

  assign count   = count_q;
  assign expired = sw_pkg::at_limit(32'(count_q), LIM32);
endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES    = 2,
  localparam int unsigned CW            = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_en,
  input  logic wdi,
  input  logic supply_low,
  output logic wdo_n
);
  logic          wdi_sync;
  logic          wdi_edge;
  logic [CW-1:0] timer_count;
  logic          timer_expired;

  sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (wdi),
    .dout (wdi_sync)
  );

  sw_edge_det u_edge (
    .clk     (clk),
    .level   (wdi_sync),
    .toggled (wdi_edge)
  );

  sw_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (wd_en),
    .clear   (wdi_edge),
    .count   (timer_count),
    .expired (timer_expired)
  );

  assign wdo_n = sw_pkg::out_level(supply_low, wd_en, timer_expired);
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int unsigned T  = 1000,
  localparam int unsigned CW = $clog2(T + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wd_en,
  input logic          supply_low,
  input logic          wdo_n,
  input logic          edge_seen,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LIM = CW'(T);

  // R1: one step below the limit with no edge leads to a low output
  p_expire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && !edge_seen && cnt == LIM - 1'b1) |=> (!wd_en || !wdo_n));

  // R1: counting advances by one per cycle below the limit
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_en && !edge_seen && cnt != LIM) |=> (!wd_en || cnt == $past(cnt) + 1'b1));

  // R2: a detected edge clears the count
  p_clear_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> (cnt == '0));

  // R3: the first cycle out of reset starts from a cleared count
  p_reset_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt == '0));

  // R4: supply-low always pulls the output low
  p_supply_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !wdo_n);

  // R5: disabled and supply good means the output stays high
  p_disabled_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !supply_low) |-> wdo_n);

  // R6: a timeout report persists until an edge or disable intervenes
  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n && !supply_low && wd_en && !edge_seen) |=> (!wd_en || !wdo_n));

  // R7: the count never wraps from the limit
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LIM && wd_en && !edge_seen) |=> (!wd_en || cnt == LIM));
endmodule

bind stall_watchdog sw_checker #(.T(TIMEOUT_CYCLES)) u_sw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wd_en      (wd_en),
  .supply_low (supply_low),
  .wdo_n      (wdo_n),
  .edge_seen  (wdi_edge),
  .cnt        (timer_count)
);

// File: tb/stall_watchdog_bench.sv
`timescale 1ns/1ps
module stall_watchdog_bench;
  localparam int unsigned T = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_en = 1'b1;
  logic wdi = 1'b0;
  logic supply_low = 1'b0;
  logic wdo_n;

  always #5 clk = ~clk;

  stall_watchdog #(.TIMEOUT_CYCLES(T)) u_stall_watchdog (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .wdi(wdi),
    .supply_low(supply_low), .wdo_n(wdo_n)
  );

  typedef struct {
    int unsigned at;
    logic        val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int unsigned cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare scheduled expectations shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() != 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.at < cyc) begin
          fails++;
          $display("FAIL %s: expectation for cycle %0d missed (now %0d) actual=%b expected=%b",
                   e.tag, e.at, cyc, wdo_n, e.val);
        end else if (wdo_n !== e.val) begin
          fails++;
          $display("FAIL %s: cycle %0d wdo_n actual=%b expected=%b", e.tag, cyc, wdo_n, e.val);
        end
      end
    end
  end

  // Driver helpers (all act at a falling edge)
  task automatic expect_at(input int unsigned k, input logic v, input string tag);
    exp_t e;
    e.at = cyc + k; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cycles(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // Reset held well beyond the timeout
    expect_at(1, 1'b1, "R3");
    expect_at(T + 20, 1'b1, "R3");
    wait_cycles(T + 20);
    drain();
    // Supply-low during reset
    supply_low = 1'b1;
    expect_at(1, 1'b0, "R4");
    wait_cycles(2);
    supply_low = 1'b0;
    expect_at(1, 1'b1, "R4");
    wait_cycles(3);
    drain();

    // Release: count T edges with no activity
    rst_n = 1'b1;
    expect_at(T - 1, 1'b1, "R1");
    expect_at(T, 1'b0, "R1");
    expect_at(3 * T + 40, 1'b0, "R7");
    drain();

    // Rising change clears after expiry
    wdi = 1'b1;
    expect_at(2, 1'b0, "R6");
    expect_at(3, 1'b1, "R2 rising");
    expect_at(T + 2, 1'b1, "R1");
    expect_at(T + 3, 0, "R1");
    drain();

    // Falling change clears, then a change timed to land on the limit edge
    wdi = 1'b0;
    expect_at(2, 1'b0, "R6");
    expect_at(3, 1'b1, "R2 falling");
    wait_cycles(T);        // counter now at T-3
    wdi = 1'b1;
    expect_at(1, 1'b1, "R8");
    expect_at(2, 1'b1, "R8");
    expect_at(3, 1'b1, "R8");
    expect_at(4, 1'b1, "R8");
    expect_at(T + 2, 1'b1, "R1");
    expect_at(T + 3, 1'b0, "R1");
    drain();

    // Supply-low while counting
    wdi = 1'b0;
    wait_cycles(5);
    supply_low = 1'b1;
    expect_at(1, 1'b0, "R4");
    wait_cycles(3);
    supply_low = 1'b0;
    expect_at(1, 1'b1, "R4");
    drain();

    // Disable for a long stretch, supply-low while disabled, re-enable
    wd_en = 1'b0;
    expect_at(1, 1'b1, "R5");
    expect_at(3 * T, 1'b1, "R5");
    drain();
    supply_low = 1'b1;
    expect_at(1, 1'b0, "R5");
    wait_cycles(2);
    supply_low = 1'b0;
    expect_at(1, 1'b1, "R5");
    wait_cycles(2);
    wd_en = 1'b1;
    expect_at(T - 1, 1'b1, "R5");
    expect_at(T, 1'b0, "R5");
    drain();

    // Reset clears a pending timeout
    rst_n = 1'b0;
    expect_at(1, 1'b1, "R6 reset");
    wait_cycles(4);
    rst_n = 1'b1;
    expect_at(T - 1, 1'b1, "R3");
    expect_at(T, 1'b0, "R3");
    drain();

    wait_cycles(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog for a hung run
  initial begin
    wait_cycles(20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule